// File: doc/BRIEF.md
# Memory Supply Switch Sequencer

This block moves the supply of the on-chip memory arrays between two rails: the CPU cluster rail (APCC) and the shared memory rail (MX). It takes over a sequence that would otherwise be run in software. A single request carries the target rail. While it is busy, the block drives the control outputs in a fixed order:

- six power-manager event lines,
- a global clock-mux select code,
- one control code for each of the two cluster PLLs,
- a mode command to the array power mux.

It then polls the mux's 4-bit status until the status reports completion or the poll limit is reached.

On older silicon the arrays cannot be switched while the clusters run from their own PLLs. For that silicon the block first parks the power-manager events and moves the clocks to an alternate source. It restores both once the switch has finished. A hardware-revision input, sampled when a request is accepted, decides whether these extra steps run. The order of the restore depends on the direction of the switch. After a move to MX the clocks come back first. After a move to APCC the events come back first.

The request port is a valid/ready pair. `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester need not hold `req_valid`: a request raised while the block is busy is simply not taken and leaves no trace. All delays are counted in clock cycles derived from `CLK_MHZ`. The 200 ns spacing is rounded up to whole cycles. At the defaults the delays are:

| Delay | Length | Cycles |
|---|---|---|
| Wake wait `W` | 2 us | 200 |
| Write spacing `S` | 200 ns | 20 |
| Poll period `P` | 1 us | 100 |
| Poll limit | 10 polls | — |

Top module: `rail_switch_seq`

## Requirements

In these requirements, t is the number of clock edges since the edge that accepted the request (that edge is t=0). A rail value of 0 means APCC and 1 means MX.

- R1: During reset and right after it:
  - `evt_o` is all ones, `gmux_code` is 0x03, and both PLL codes are 0x30.
  - `mode_cmd` is 0x10, `rail_cur` is 0 (APCC), and `busy`, `done` and `timeout` are 0.
  - `req_ready` is 1.
- R2: A request is accepted at an edge where `req_valid` and `req_ready` are both 1.
  - The block samples `req_rail` and `hw_rev` at that edge.
  - `busy` rises at that edge and falls at the edge where `done` pulses.
  - `req_ready` equals the inverse of `busy`, so a request raised while busy has no effect on any output.
- R3: When `hw_rev` < 0x10020000 (legacy path), all event lines drop to 0 at t=0.
- R4: On the legacy path the clock move writes its codes at fixed points, with consecutive writes spaced by `S`:
  - `gmux_code` becomes 0x13 at t=W.
  - `pll0_code` becomes 0xB0 at t=W+S.
  - `pll1_code` becomes 0xB0 at t=W+2S.
- R5: `mode_cmd` becomes 0x00 for a move to MX or 0x10 for a move to APCC.
  - On the legacy path it changes at t=M=W+3S.
  - Otherwise it changes at t=M=0.
  - It never changes while the block is idle.
- R6: The status is polled up to 10 times, at t=M+1+k·P for k=0..9.
  - A poll succeeds when `mux_sts` is 0x0 for MX or 0x3 for APCC.
  - The first successful poll ends polling. A match on the tenth poll still counts as a success.
- R7: If none of the 10 polls matches, `timeout` pulses together with `done` and `rail_cur` keeps its old value.
- R8: When `hw_rev` >= 0x10020000 (this includes the threshold value itself), only the mode write and the polling take place.
  - The event lines, `gmux_code` and both PLL codes do not change.
  - `done` pulses at the edge of the deciding poll R.
- R9: For a legacy move to MX, counting from the deciding poll R:
  - `gmux_code` returns to 0x03 at R.
  - `pll0_code` returns to 0x30 at R+S, and `pll1_code` at R+2S.
  - The event lines return to all ones, with `done`, at R+3S. This happens after a timeout as well.
- R10: For a legacy move to APCC, counting from the deciding poll R:
  - The event lines return to all ones at R.
  - `gmux_code` returns to 0x03 at R+S.
  - `pll0_code` returns to 0x30 at R+2S, and `pll1_code`, with `done`, at R+3S.
- R11: `rail_cur` changes only at the edge where `done` pulses. It takes the requested rail only when the switch succeeded.
- R12: `done` is a one-cycle pulse, and `timeout` is never high without `done`.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Switch request valid |
| req_ready | output | 1 | High when a request can be taken (idle) |
| req_rail | input | 1 | Target rail: 0 APCC, 1 MX |
| hw_rev | input | REV_W | Hardware revision, compared with REV_THRESH |
| mux_sts | input | 4 | Completion status from the array power mux |
| evt_o | output | NUM_EVT | Power-manager event lines, 1 = set, 0 = cleared |
| gmux_code | output | 8 | Global clock-mux select code |
| pll0_code | output | 8 | First cluster PLL control code |
| pll1_code | output | 8 | Second cluster PLL control code |
| mode_cmd | output | 8 | Mode command to the array power mux |
| busy | output | 1 | A switch is in progress |
| done | output | 1 | One-cycle pulse at the end of a switch |
| timeout | output | 1 | With done: the status never matched |
| rail_cur | output | 1 | Rail now powering the arrays: 0 APCC, 1 MX |

## Verification

The assertions check the following on every cycle:

- An accepted request makes the block busy, and `busy` falls only with `done`.
- `done` is a single pulse, and `timeout` never appears without it.
- The rail register moves only on `done` and never on a timeout.
- The event lines always move as one group.
- While idle, every clock code is back home and the mode command holds still.

Only the bench's scenarios, compared every cycle against a timeline model, can show the rest:

- the exact edges of the wake wait, the write spacing and the poll instants,
- the direction-dependent restore order,
- the boundary at the revision threshold,
- a match on the very last poll,
- a request ignored in the middle of a switch.

// File: rtl/rail_switch_pkg.sv
package rail_switch_pkg;

  typedef enum logic {
    RAIL_APCC = 1'b0,
    RAIL_MX   = 1'b1
  } rail_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAKE,
    ST_CK0,
    ST_CK1,
    ST_MODE,
    ST_POLL,
    ST_RS1,
    ST_RS2,
    ST_RS3
  } seq_st_e;

  localparam logic [7:0] GMUX_ALT  = 8'h13;
  localparam logic [7:0] GMUX_HOME = 8'h03;
  localparam logic [7:0] PLL_OVR   = 8'hB0;
  localparam logic [7:0] PLL_SEC   = 8'h30;
  localparam logic [7:0] MODE_MX   = 8'h00;
  localparam logic [7:0] MODE_APCC = 8'h10;
  localparam logic [3:0] STS_MX    = 4'h0;
  localparam logic [3:0] STS_APCC  = 4'h3;
  localparam logic [3:0] STS_MASK  = 4'hF;

  function automatic logic [7:0] mode_of(rail_e r);
    return (r == RAIL_MX) ? MODE_MX : MODE_APCC;
  endfunction

  function automatic logic [3:0] sts_of(rail_e r);
    return (r == RAIL_MX) ? STS_MX : STS_APCC;
  endfunction

endpackage

// File: rtl/rs_cycle_timer.sv
module rs_cycle_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/rs_sts_match.sv
module rs_sts_match
  import rail_switch_pkg::*;
(
  input  logic [3:0] sts,
  input  rail_e      target,
  output logic       hit
);

  assign hit = ((sts & STS_MASK) == sts_of(target));

endmodule

// File: rtl/rs_seq_fsm.sv
module rs_seq_fsm
  import rail_switch_pkg::*;
#(
  parameter int unsigned NUM_EVT    = 6,
  parameter int unsigned REV_W      = 32,
  parameter logic [REV_W-1:0] REV_THRESH = 32'h1002_0000,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned WAKE_CYC   = 200,
  parameter int unsigned SP_CYC     = 20,
  parameter int unsigned POLL_CYC   = 100,
  parameter int unsigned MAX_POLLS  = 10,
  parameter int unsigned POLL_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc,
  input  rail_e              req_rail,
  input  logic [REV_W-1:0]   hw_rev,
  input  logic               tmr_zero,
  input  logic               sts_hit,
  output logic               tmr_load,
  output logic [CNT_W-1:0]   tmr_val,
  output rail_e              tgt_rail,
  output logic               busy,
  output logic               done,
  output logic               timeout,
  output rail_e              rail_cur,
  output logic [NUM_EVT-1:0] evt,
  output logic [7:0]         gmux,
  output logic [7:0]         pll0,
  output logic [7:0]         pll1,
  output logic [7:0]         mode
);

  localparam logic [CNT_W-1:0]  WAKE_LD = CNT_W'(WAKE_CYC - 1);
  localparam logic [CNT_W-1:0]  SP_LD   = CNT_W'(SP_CYC - 1);
  localparam logic [CNT_W-1:0]  POLL_LD = CNT_W'(POLL_CYC - 1);
  localparam logic [POLL_W-1:0] LAST_PL = POLL_W'(MAX_POLLS - 1);

  seq_st_e           st, st_n;
  logic              act, fin, leg_in, leg_q, ok_q, ok_fin, last_poll, decide;
  logic [POLL_W-1:0] polls;

  assign leg_in    = (hw_rev < REV_THRESH);
  assign last_poll = (polls == LAST_PL);
  assign decide    = sts_hit | last_poll;
  assign ok_fin    = (st == ST_POLL) ? sts_hit : ok_q;

  always_comb begin
    st_n     = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    act      = 1'b0;
    fin      = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (acc) begin
          act      = 1'b1;
          tmr_load = 1'b1;
          if (leg_in) begin
            st_n    = ST_WAKE;
            tmr_val = WAKE_LD;
          end else begin
            st_n    = ST_POLL;
          end
        end
      end
      ST_WAKE, ST_CK0, ST_CK1: begin
        if (tmr_zero) begin
          act      = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = SP_LD;
          st_n     = (st == ST_WAKE) ? ST_CK0 : (st == ST_CK0) ? ST_CK1 : ST_MODE;
        end
      end
      ST_MODE: begin
        if (tmr_zero) begin
          act      = 1'b1;
          tmr_load = 1'b1;
          st_n     = ST_POLL;
        end
      end
      ST_POLL: begin
        if (tmr_zero) begin
          act      = 1'b1;
          tmr_load = 1'b1;
          if (!decide) begin
            tmr_val = POLL_LD;
          end else if (leg_q) begin
            tmr_val = SP_LD;
            st_n    = ST_RS1;
          end else begin
            st_n    = ST_IDLE;
            fin     = 1'b1;
          end
        end
      end
      ST_RS1, ST_RS2: begin
        if (tmr_zero) begin
          act      = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = SP_LD;
          st_n     = (st == ST_RS1) ? ST_RS2 : ST_RS3;
        end
      end
      ST_RS3: begin
        if (tmr_zero) begin
          act  = 1'b1;
          fin  = 1'b1;
          st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      timeout  <= 1'b0;
      rail_cur <= RAIL_APCC;
      tgt_rail <= RAIL_APCC;
      evt      <= '1;
      gmux     <= GMUX_HOME;
      pll0     <= PLL_SEC;
      pll1     <= PLL_SEC;
      mode     <= MODE_APCC;
      leg_q    <= 1'b0;
      ok_q     <= 1'b0;
      polls    <= '0;
    end else begin
      st      <= st_n;
      done    <= fin;
      timeout <= fin & ~ok_fin;
      if (fin) begin
        busy <= 1'b0;
        if (ok_fin) rail_cur <= tgt_rail;
      end
      if (act) begin
        unique case (st)
          ST_IDLE: begin
            busy     <= 1'b1;
            tgt_rail <= req_rail;
            leg_q    <= leg_in;
            polls    <= '0;
            if (leg_in) evt  <= '0;
            else        mode <= mode_of(req_rail);
          end
          ST_WAKE: gmux <= GMUX_ALT;
          ST_CK0:  pll0 <= PLL_OVR;
          ST_CK1:  pll1 <= PLL_OVR;
          ST_MODE: begin
            mode  <= mode_of(tgt_rail);
            polls <= '0;
          end
          ST_POLL: begin
            if (decide) begin
              ok_q <= sts_hit;
              if (leg_q) begin
                if (tgt_rail == RAIL_MX) gmux <= GMUX_HOME;
                else                     evt  <= '1;
              end
            end else begin
              polls <= polls + 1'b1;
            end
          end
          ST_RS1: begin
            if (tgt_rail == RAIL_MX) pll0 <= PLL_SEC;
            else                     gmux <= GMUX_HOME;
          end
          ST_RS2: begin
            if (tgt_rail == RAIL_MX) pll1 <= PLL_SEC;
            else                     pll0 <= PLL_SEC;
          end
          ST_RS3: begin
            if (tgt_rail == RAIL_MX) evt  <= '1;
            else                     pll1 <= PLL_SEC;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/rail_switch_seq.sv
module rail_switch_seq
  import rail_switch_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 100,
  parameter int unsigned WAKE_US    = 2,
  parameter int unsigned SPACE_NS   = 200,
  parameter int unsigned POLL_US    = 1,
  parameter int unsigned MAX_POLLS  = 10,
  parameter int unsigned NUM_EVT    = 6,
  parameter int unsigned REV_W      = 32,
  parameter logic [REV_W-1:0] REV_THRESH = 32'h1002_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_rail,
  input  logic [REV_W-1:0]   hw_rev,
  input  logic [3:0]         mux_sts,
  output logic [NUM_EVT-1:0] evt_o,
  output logic [7:0]         gmux_code,
  output logic [7:0]         pll0_code,
  output logic [7:0]         pll1_code,
  output logic [7:0]         mode_cmd,
  output logic               busy,
  output logic               done,
  output logic               timeout,
  output logic               rail_cur
);

  localparam int unsigned WAKE_RAW = WAKE_US * CLK_MHZ;
  localparam int unsigned SP_RAW   = (SPACE_NS * CLK_MHZ + 999) / 1000;
  localparam int unsigned POLL_RAW = POLL_US * CLK_MHZ;
  localparam int unsigned WAKE_CYC = (WAKE_RAW > 0) ? WAKE_RAW : 1;
  localparam int unsigned SP_CYC   = (SP_RAW > 0) ? SP_RAW : 1;
  localparam int unsigned POLL_CYC = (POLL_RAW > 0) ? POLL_RAW : 1;
  localparam int unsigned MAX_AB   = (WAKE_CYC > SP_CYC) ? WAKE_CYC : SP_CYC;
  localparam int unsigned MAX_CYC  = (MAX_AB > POLL_CYC) ? MAX_AB : POLL_CYC;
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);
  localparam int unsigned POLL_W   = $clog2(MAX_POLLS + 1);

  logic             acc, tmr_load, tmr_zero, sts_hit;
  logic [CNT_W-1:0] tmr_val;
  rail_e            tgt_rail, rail_q;

  assign req_ready = ~busy;
  assign acc       = req_valid & req_ready;
  assign rail_cur  = rail_q;

  rs_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  rs_sts_match u_match (
    .sts    (mux_sts),
    .target (tgt_rail),
    .hit    (sts_hit)
  );

  rs_seq_fsm #(
    .NUM_EVT    (NUM_EVT),
    .REV_W      (REV_W),
    .REV_THRESH (REV_THRESH),
    .CNT_W      (CNT_W),
    .WAKE_CYC   (WAKE_CYC),
    .SP_CYC     (SP_CYC),
    .POLL_CYC   (POLL_CYC),
    .MAX_POLLS  (MAX_POLLS),
    .POLL_W     (POLL_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .req_rail (rail_e'(req_rail)),
    .hw_rev   (hw_rev),
    .tmr_zero (tmr_zero),
    .sts_hit  (sts_hit),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .tgt_rail (tgt_rail),
    .busy     (busy),
    .done     (done),
    .timeout  (timeout),
    .rail_cur (rail_q),
    .evt      (evt_o),
    .gmux     (gmux_code),
    .pll0     (pll0_code),
    .pll1     (pll1_code),
    .mode     (mode_cmd)
  );

endmodule

// File: rtl/rail_switch_seq_checker.sv
module rail_switch_seq_checker #(
  parameter int unsigned NUM_EVT = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               busy,
  input logic               done,
  input logic               timeout,
  input logic               rail_cur,
  input logic [NUM_EVT-1:0] evt_o,
  input logic [7:0]         gmux_code,
  input logic [7:0]         pll0_code,
  input logic [7:0]         pll1_code,
  input logic [7:0]         mode_cmd
);

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy); // R2

  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R2

  AST_EVT_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(evt_o) == 0) || ($countones(evt_o) == NUM_EVT)); // R3

  AST_MODE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> $stable(mode_cmd)); // R5

  AST_TIMEOUT_KEEPS_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> $stable(rail_cur)); // R7

  AST_IDLE_CLOCKS_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (gmux_code == 8'h03 && pll0_code == 8'h30 &&
               pll1_code == 8'h30 && evt_o == {NUM_EVT{1'b1}})); // R9

  AST_RAIL_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rail_cur)); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

  AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> done); // R12

endmodule

bind rail_switch_seq rail_switch_seq_checker #(.NUM_EVT(NUM_EVT)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .timeout   (timeout),
  .rail_cur  (rail_cur),
  .evt_o     (evt_o),
  .gmux_code (gmux_code),
  .pll0_code (pll0_code),
  .pll1_code (pll1_code),
  .mode_cmd  (mode_cmd)
);

// File: tb/rail_switch_seq_bench.sv
`timescale 1ns/1ps
module rail_switch_seq_bench;

  localparam int W    = 200;
  localparam int SP   = 20;
  localparam int POLL = 100;
  localparam int MAXP = 10;
  localparam logic [31:0] THR = 32'h1002_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_rail = 1'b0;
  logic [31:0] hw_rev = 32'h0;
  logic [3:0]  mux_sts = 4'h0;
  logic        req_ready, busy, done, timeout, rail_cur;
  logic [5:0]  evt_o;
  logic [7:0]  gmux_code, pll0_code, pll1_code, mode_cmd;

  always #5 clk = ~clk;

  rail_switch_seq u_rail_switch_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rail(req_rail), .hw_rev(hw_rev), .mux_sts(mux_sts), .evt_o(evt_o),
    .gmux_code(gmux_code), .pll0_code(pll0_code), .pll1_code(pll1_code),
    .mode_cmd(mode_cmd), .busy(busy), .done(done), .timeout(timeout),
    .rail_cur(rail_cur)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit started = 0;

  task automatic chk(input string tag, input string nm, input int a, input int e);
    n_cmp++;
    if (a != e) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, a, e, $time);
    end
  endtask

  // timeline reference model
  int   m_busy = 0, m_done = 0, m_to = 0, m_rail = 0;
  int   m_evt = 63, m_gmux = 8'h03, m_pll0 = 8'h30, m_pll1 = 8'h30, m_mode = 8'h10;
  int   t = 0, dir = 0, leg = 0, mt = 0, rt = 0, ok = 0, decided = 0;

  function automatic int mode_code(int d); return d ? 8'h00 : 8'h10; endfunction
  function automatic int sts_code(int d);  return d ? 4'h0 : 4'h3;  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_to = 0; m_rail = 0; m_evt = 63;
      m_gmux = 8'h03; m_pll0 = 8'h30; m_pll1 = 8'h30; m_mode = 8'h10;
    end else begin
      m_done = 0; m_to = 0;
      if (!m_busy) begin
        if (req_valid) begin
          m_busy = 1; dir = req_rail; leg = (hw_rev < THR); t = 0; decided = 0;
          if (leg) begin m_evt = 0; mt = W + 3*SP; end
          else begin m_mode = mode_code(dir); mt = 0; end
        end
      end else begin
        t = t + 1;
        if (leg) begin
          if (t == W)        m_gmux = 8'h13;
          if (t == W + SP)   m_pll0 = 8'hB0;
          if (t == W + 2*SP) m_pll1 = 8'hB0;
          if (t == mt)       m_mode = mode_code(dir);
        end
        if (!decided && t > mt && ((t - mt - 1) % POLL) == 0) begin
          if (int'(mux_sts) == sts_code(dir)) begin ok = 1; decided = 1; rt = t; end
          else if ((t - mt - 1) / POLL == MAXP - 1) begin ok = 0; decided = 1; rt = t; end
        end
        if (decided) begin
          if (leg) begin
            if (dir != 0) begin
              if (t == rt)        m_gmux = 8'h03;
              if (t == rt + SP)   m_pll0 = 8'h30;
              if (t == rt + 2*SP) m_pll1 = 8'h30;
              if (t == rt + 3*SP) m_evt  = 63;
            end else begin
              if (t == rt)        m_evt  = 63;
              if (t == rt + SP)   m_gmux = 8'h03;
              if (t == rt + 2*SP) m_pll0 = 8'h30;
              if (t == rt + 3*SP) m_pll1 = 8'h30;
            end
          end
          if (t == (leg ? rt + 3*SP : rt)) begin
            m_done = 1; m_to = !ok; m_busy = 0;
            if (ok) m_rail = dir;
          end
        end
      end
    end
  end

  // per-cycle comparison and ordering capture
  int  tg = -1, te = -1, n_run = 0, touched = 0;
  logic [7:0] prev_g = 8'h03;
  logic [5:0] prev_e = 6'h3F;

  always @(negedge clk) begin
    if (started) begin
      chk("R2",  "req_ready", req_ready, !m_busy);
      chk("R2",  "busy",      busy,      m_busy);
      chk("R3",  "evt_o",     evt_o,     m_evt);
      chk("R4",  "gmux_code", gmux_code, m_gmux);
      chk("R4",  "pll0_code", pll0_code, m_pll0);
      chk("R4",  "pll1_code", pll1_code, m_pll1);
      chk("R5",  "mode_cmd",  mode_cmd,  m_mode);
      chk("R12", "done",      done,      m_done);
      chk("R7",  "timeout",   timeout,   m_to);
      chk("R11", "rail_cur",  rail_cur,  m_rail);
      if (gmux_code == 8'h03 && prev_g != 8'h03) tg = n_run;
      if (evt_o == 6'h3F && prev_e != 6'h3F) te = n_run;
      if (gmux_code != 8'h03 || evt_o != 6'h3F) touched = 1;
      prev_g = gmux_code;
      prev_e = evt_o;
    end
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic run_switch(input logic rail, input logic [31:0] rev,
                            input logic [3:0] pre, input logic [3:0] post,
                            input int change_at, input int poke_at);
    @(negedge clk);
    mux_sts = pre; req_rail = rail; hw_rev = rev; req_valid = 1'b1;
    tg = -1; te = -1; touched = 0; n_run = 0;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && n_run < 5000) begin
      @(negedge clk);
      n_run++;
      if (n_run == change_at) mux_sts = post;
      if (n_run == poke_at) begin req_valid = 1'b1; req_rail = ~rail; end
      else req_valid = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "evt_o", evt_o, 6'h3F);
    chk("R1", "gmux_code", gmux_code, 8'h03);
    chk("R1", "pll0_code", pll0_code, 8'h30);
    chk("R1", "pll1_code", pll1_code, 8'h30);
    chk("R1", "mode_cmd", mode_cmd, 8'h10);
    chk("R1", "busy", busy, 0);
    chk("R1", "rail_cur", rail_cur, 0);
    chk("R1", "req_ready", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    started = 1;

    // R9: legacy move to MX, first poll matches
    run_switch(1'b1, 32'h1000_0000, 4'h0, 4'h0, -1, -1);
    chk("R9", "rail_cur", rail_cur, 1);
    chk("R9", "clocks_before_events", (tg >= 0 && te > tg), 1);

    // R10: legacy move to APCC, match on the fourth poll
    run_switch(1'b0, 32'h1000_0000, 4'h0, 4'h3, 500, -1);
    chk("R10", "rail_cur", rail_cur, 0);
    chk("R10", "events_before_clocks", (te >= 0 && tg > te), 1);

    // R7: legacy move to MX that never completes
    run_switch(1'b1, 32'h1000_0000, 4'h3, 4'h3, -1, -1);
    chk("R7", "rail_cur_kept", rail_cur, 0);
    chk("R7", "restore_after_timeout", (tg >= 0 && te > tg), 1);

    // R8: revision at threshold, MX success on the third poll
    run_switch(1'b1, THR, 4'h3, 4'h0, 150, -1);
    chk("R8", "rail_cur", rail_cur, 1);
    chk("R8", "clocks_events_untouched", touched, 0);

    // R8: new revision, APCC timeout with masked-mismatch status
    run_switch(1'b0, 32'hFFFF_0000, 4'h5, 4'h5, -1, -1);
    chk("R8", "rail_cur_kept", rail_cur, 1);
    chk("R8", "untouched_on_timeout", touched, 0);

    // R6: just below threshold, match only on the tenth poll; R2 poke ignored
    run_switch(1'b0, THR - 32'h1, 4'h0, 4'h3, W + 3*SP + 1 + 9*POLL - 4, 40);
    chk("R6", "rail_cur_last_poll", rail_cur, 0);
    chk("R2", "busy_after_ignored_req", busy, 0);

    // R11: new revision, immediate MX success
    run_switch(1'b1, 32'h2000_0000, 4'h0, 4'h0, -1, -1);
    chk("R11", "rail_cur", rail_cur, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule